// File: doc/BRIEF.md
# Interlocked Parallel Handshake Port

This block moves 8-bit or 16-bit words between two identical devices over a parallel data bus with two control wires: each side has one strobe output and one strobe input, with the output of one side wired to the input of the other. Both control wires are active low. A mode input sets the direction. As a transmitter, the block drives its strobe output as the "data ready" strobe and reads the peer's acknowledge on its strobe input. As a receiver, it reads the peer's strobe on its strobe input and drives its own acknowledge on its strobe output.

On the transmit side, local logic loads a word through a write port. The block waits a programmable number of setup cycles and then asserts the strobe. It drops the strobe once the peer's acknowledge arrives. It does not strobe again until a new word has been loaded and the acknowledge has returned high. On the receive side, the incoming word is captured when the peer's strobe is seen low, and the acknowledge is asserted. The acknowledge is held until local logic reads the word through a read port.

The strobe input passes through a multi-flop synchronizer before any decision uses it. The bus width in use is chosen at run time, and only the low byte is carried in narrow mode.

Top module: `ilk_par_port`

## Requirements
- R1: After reset the strobe output `strb_out` is high, `rx_valid` is low, and with `mode_tx` high `tx_ready` is high.
- R2: With `mode_tx` high and the synchronized strobe input high, a word accepted at clock edge e0 with `setup_cyc` = N makes `strb_out` go low right after edge eN. With N = 0 that is right after the load edge. It stays high before then.
- R3: `bus_oe` equals `mode_tx`. While transmitting, `bus_out` carries the loaded word and stays stable while `strb_out` is low.
- R4: While transmitting, once the strobe input has been low long enough to pass the two-flop synchronizer, `strb_out` returns high and `tx_ready` goes high.
- R5: After a delivered word, `strb_out` stays high until a new word has been loaded and the strobe input has been seen high again.
- R6: A write with `wr_en` high while `tx_ready` is low is ignored, and `bus_out` keeps the earlier word.
- R7: With `wide_sel` low, only bits [7:0] are carried. `bus_out` bits [15:8] read 0 for a transmitted word, and `rd_data` bits [15:8] read 0 for a received word. With `wide_sel` high, all 16 bits are carried.
- R8: With `mode_tx` low, a low level on the synchronized strobe input captures `bus_in` into the input latch, raises `rx_valid`, and drives `strb_out` low as the acknowledge.
- R9: The receiver keeps `strb_out` low and `rx_valid` high until a one-cycle `rd_en` pulse. After that pulse, `strb_out` is high and `rx_valid` is low.
- R10: After a read, no new word is captured while the strobe input stays low. Capture resumes only after the strobe input has been seen high.
- R11: A change of `mode_tx` returns the block to idle. On the following cycle `strb_out` is high and `rx_valid` is low, and the new direction is ready for use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_tx | input | 1 | 1 = transmitter, 0 = receiver |
| wide_sel | input | 1 | 1 = 16-bit words, 0 = low byte only |
| setup_cyc | input | 4 | Setup delay before strobe, in cycles |
| wr_en | input | 1 | Load `wr_data` into the output latch |
| wr_data | input | 16 | Word to transmit |
| tx_ready | output | 1 | Output latch can take a word |
| rd_en | input | 1 | One-cycle read of the input latch |
| rd_data | output | 16 | Received word |
| rx_valid | output | 1 | Input latch holds an unread word |
| strb_out | output | 1 | Active-low strobe (transmit) or acknowledge (receive) |
| strb_in | input | 1 | Active-low peer acknowledge (transmit) or peer strobe (receive) |
| bus_out | output | 16 | Parallel data driven while transmitting |
| bus_oe | output | 1 | Data bus drive enable |
| bus_in | input | 16 | Parallel data sampled while receiving |

## Verification
The transmit path runs with setup delays of zero and five cycles. Counting the exact cycle of the strobe's fall separates an off-by-one counter from a correct one. The path also runs with the acknowledge still held low when the next word arrives, which shows whether the block waits for the acknowledge to return high. The receive path holds the peer strobe low across and after a read, so a receiver that re-captures the same word or drops its acknowledge early is caught. Wide and narrow words with distinct upper bytes show whether the width mask is applied in each direction. A mode switch while a received word is pending checks that both sides return to idle.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_SETUP = 2'd1,
      TX_STB   = 2'd2
   } tx_st_e;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_FULL  = 2'd1,
      RX_DRAIN = 2'd2
   } rx_st_e;
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ilk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ilk_tx.sv
module ilk_tx
   import ilk_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CNT_W-1:0]  setup_cyc,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ack_s,
   output logic              tx_ready,
   output logic              stb_n,
   output logic [DATA_W-1:0] dout
);
   tx_st_e             st;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  lat;
   logic               load;

   assign tx_ready = en && (st == TX_IDLE);
   assign load     = wr_en && tx_ready;
   assign stb_n    = (st != TX_STB);
   assign dout     = lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= TX_IDLE;
         cnt <= '0;
         lat <= '0;
      end else if (!en) begin
         st  <= TX_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            TX_IDLE: begin
               if (load) begin
                  lat <= wr_data;
                  if (setup_cyc == '0) begin
                     cnt <= '0;
                     st  <= ack_s ? TX_STB : TX_SETUP;
                  end else begin
                     cnt <= setup_cyc - 1'b1;
                     st  <= TX_SETUP;
                  end
               end
            end
            TX_SETUP: begin
               if (cnt != '0)  cnt <= cnt - 1'b1;
               else if (ack_s) st  <= TX_STB;
            end
            TX_STB: begin
               if (!ack_s) st <= TX_IDLE;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_ready) |=> $stable(lat)); // R6

   AST_STB_NEEDS_ACK_HI: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $fell(stb_n) |-> $past(ack_s)); // R5

   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_n && $past(!stb_n)) |-> $stable(dout)); // R3
endmodule

// File: rtl/ilk_rx.sv
module ilk_rx
   import ilk_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stb_s,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_en,
   output logic              valid,
   output logic              ack_n,
   output logic [DATA_W-1:0] dout
);
   rx_st_e            st;
   logic [DATA_W-1:0] lat;

   assign valid = (st == RX_FULL);
   assign ack_n = (st != RX_FULL);
   assign dout  = lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= RX_IDLE;
         lat <= '0;
      end else if (!en) begin
         st  <= RX_IDLE;
      end else begin
         unique case (st)
            RX_IDLE: begin
               if (!stb_s) begin
                  lat <= din;
                  st  <= RX_FULL;
               end
            end
            RX_FULL:  if (rd_en) st <= RX_DRAIN;
            RX_DRAIN: if (stb_s) st <= RX_IDLE;
            default:  st <= RX_IDLE;
         endcase
      end
   end

   AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n || !en)
      (!ack_n && !rd_en) |=> (!ack_n && valid)); // R9

   AST_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !en)
      ((st == RX_DRAIN) && !stb_s) |=> !valid); // R10

   AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(valid)) |-> $stable(dout)); // R8
endmodule

// File: rtl/ilk_par_port.sv
module ilk_par_port #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int CNT_W    = 4,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_tx,
   input  logic              wide_sel,
   input  logic [CNT_W-1:0]  setup_cyc,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_ready,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_valid,
   output logic              strb_out,
   input  logic              strb_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_in
);
   localparam int UPPER_W = DATA_W - NARROW_W;

   generate
      if (NARROW_W < 1 || DATA_W < NARROW_W) begin : g_bad_width
         $error("ilk_par_port: need 1 <= NARROW_W <= DATA_W");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ilk_par_port: CNT_W must be positive");
      end
   endgenerate

   logic              mode_q;
   logic              flush;
   logic              tx_en;
   logic              rx_en;
   logic              strb_s;
   logic              tx_stb_n;
   logic              rx_ack_n;
   logic [DATA_W-1:0] wmask;

   generate
      if (UPPER_W > 0) begin : g_mask_split
         assign wmask = wide_sel ? {DATA_W{1'b1}}
                                 : {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};
      end else begin : g_mask_full
         assign wmask = {DATA_W{1'b1}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= mode_tx;
   end

   assign flush = mode_tx ^ mode_q;
   assign tx_en = mode_tx & ~flush;
   assign rx_en = ~mode_tx & ~flush;

   ilk_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (strb_in),
      .q     (strb_s)
   );

   ilk_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tx_en),
      .setup_cyc (setup_cyc),
      .wr_en     (wr_en),
      .wr_data   (wr_data & wmask),
      .ack_s     (strb_s),
      .tx_ready  (tx_ready),
      .stb_n     (tx_stb_n),
      .dout      (bus_out)
   );

   ilk_rx #(.DATA_W(DATA_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rx_en),
      .stb_s (strb_s),
      .din   (bus_in & wmask),
      .rd_en (rd_en),
      .valid (rx_valid),
      .ack_n (rx_ack_n),
      .dout  (rd_data)
   );

   assign strb_out = flush | (mode_tx ? tx_stb_n : rx_ack_n);
   assign bus_oe   = mode_tx;

   AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (strb_out && !rx_valid)); // R11

   AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ready && rx_valid)); // R11
endmodule

// File: tb/sim_ilk_par_port.sv
module sim_ilk_par_port;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_tx = 1'b1;
   logic        wide_sel = 1'b1;
   logic [3:0]  setup_cyc = 4'd0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = 16'h0;
   logic        tx_ready;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        rx_valid;
   logic        strb_out;
   logic        strb_in = 1'b1;
   logic [15:0] bus_out;
   logic        bus_oe;
   logic [15:0] bus_in = 16'h0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ilk_par_port u0 (
      .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .wide_sel(wide_sel),
      .setup_cyc(setup_cyc), .wr_en(wr_en), .wr_data(wr_data),
      .tx_ready(tx_ready), .rd_en(rd_en), .rd_data(rd_data),
      .rx_valid(rx_valid), .strb_out(strb_out), .strb_in(strb_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // wait up to lim cycles for strb_out to reach val; returns cycles waited
   task automatic wait_strb(input logic val, input int lim, output int took);
      took = 0;
      while (strb_out !== val && took < lim) begin
         @(negedge clk);
         took++;
      end
   endtask

   task automatic write_word(input logic [15:0] w);
      wr_data = w;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // peer acknowledges a transmitted word, then releases
   task automatic peer_ack(input string tag);
      int t;
      strb_in = 1'b0;
      wait_strb(1'b1, 10, t);
      check({tag, " strobe released after ack"}, {31'd0, strb_out}, 32'd1);
      check({tag, " tx_ready after ack"}, {31'd0, tx_ready}, 32'd1);
      strb_in = 1'b1;
      cyc(4);
   endtask

   task automatic t_reset;
      check("R1 strb_out", {31'd0, strb_out}, 32'd1);
      check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
      check("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
      check("R3 bus_oe in tx", {31'd0, bus_oe}, 32'd1);
   endtask

   task automatic t_setup(input logic [3:0] n, input logic [15:0] w);
      int early = 0;
      setup_cyc = n;
      write_word(w);
      // index 0 is the first negedge after the load edge
      for (int i = 0; i < int'(n); i++) begin
         if (strb_out !== 1'b1) early++;
         @(negedge clk);
      end
      check("R2 strobe not early", early, 0);
      check("R2 strobe low at setup end", {31'd0, strb_out}, 32'd0);
      check("R3 bus_out word", {16'd0, bus_out}, {16'd0, w});
      cyc(3);
      check("R3 bus_out held during strobe", {16'd0, bus_out}, {16'd0, w});
      peer_ack("R4");
   endtask

   task automatic t_ignore_and_wait;
      int t;
      int low_seen = 0;
      setup_cyc = 4'd0;
      write_word(16'h1357);
      check("R6 tx_ready low while busy", {31'd0, tx_ready}, 32'd0);
      write_word(16'h5555);
      check("R6 ignored write keeps word", {16'd0, bus_out}, 32'h1357);
      strb_in = 1'b0;
      wait_strb(1'b1, 10, t);
      check("R4 strobe released", {31'd0, strb_out}, 32'd1);
      check("R6 word after handshake", {16'd0, bus_out}, 32'h1357);
      // ack still low: load a new word, strobe must wait
      write_word(16'h2468);
      for (int i = 0; i < 6; i++) begin
         if (strb_out !== 1'b1) low_seen++;
         @(negedge clk);
      end
      check("R5 no strobe while ack low", low_seen, 0);
      strb_in = 1'b1;
      wait_strb(1'b0, 8, t);
      check("R5 strobe after ack high", {31'd0, strb_out}, 32'd0);
      check("R5 sync delay", (t >= 2) ? 32'd1 : 32'd0, 32'd1);
      peer_ack("R5");
   endtask

   task automatic t_tx_narrow;
      wide_sel  = 1'b0;
      setup_cyc = 4'd0;
      write_word(16'hABCD);
      check("R7 tx narrow mask", {16'd0, bus_out}, 32'h00CD);
      peer_ack("R7");
      wide_sel = 1'b1;
   endtask

   task automatic t_rx(input logic wide, input logic [15:0] w, input logic [15:0] exp);
      int t;
      int drop = 0;
      int recap = 0;
      wide_sel = wide;
      bus_in   = w;
      strb_in  = 1'b0;
      t = 0;
      while (rx_valid !== 1'b1 && t < 10) begin
         @(negedge clk);
         t++;
      end
      check("R8 rx_valid", {31'd0, rx_valid}, 32'd1);
      check("R8 ack low", {31'd0, strb_out}, 32'd0);
      check(wide ? "R8 rd_data wide" : "R7 rd_data narrow", {16'd0, rd_data}, {16'd0, exp});
      for (int i = 0; i < 5; i++) begin
         if (strb_out !== 1'b0 || rx_valid !== 1'b1) drop++;
         @(negedge clk);
      end
      check("R9 ack held until read", drop, 0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R9 ack released after read", {31'd0, strb_out}, 32'd1);
      check("R9 rx_valid cleared", {31'd0, rx_valid}, 32'd0);
      for (int i = 0; i < 6; i++) begin
         if (rx_valid !== 1'b0) recap++;
         @(negedge clk);
      end
      check("R10 no recapture while strobe low", recap, 0);
      strb_in = 1'b1;
      cyc(4);
      check("R10 idle after strobe high", {31'd0, rx_valid}, 32'd0);
      wide_sel = 1'b1;
   endtask

   task automatic t_mode_switch;
      int t;
      bus_in  = 16'hC0DE;
      strb_in = 1'b0;
      t = 0;
      while (rx_valid !== 1'b1 && t < 10) begin
         @(negedge clk);
         t++;
      end
      check("R11 pending word", {31'd0, rx_valid}, 32'd1);
      strb_in = 1'b1;
      mode_tx = 1'b1;
      @(negedge clk);
      check("R11 strb_out high on switch", {31'd0, strb_out}, 32'd1);
      check("R11 rx_valid cleared", {31'd0, rx_valid}, 32'd0);
      @(negedge clk);
      check("R11 tx_ready in new mode", {31'd0, tx_ready}, 32'd1);
      check("R3 bus_oe after switch", {31'd0, bus_oe}, 32'd1);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(4);
      t_reset();
      t_setup(4'd0, 16'hA5C3);
      t_setup(4'd5, 16'h3C69);
      t_ignore_and_wait();
      t_tx_narrow();
      mode_tx = 1'b0;
      cyc(3);
      check("R3 bus_oe in rx", {31'd0, bus_oe}, 32'd0);
      check("R11 rx idle after switch", {31'd0, strb_out}, 32'd1);
      t_rx(1'b1, 16'h1234, 16'h1234);
      t_rx(1'b0, 16'hBEEF, 16'h00EF);
      t_mode_switch();
      finish_run();
   end
endmodule